// File: doc/BRIEF.md
# Quadrature Square-Wave Clock Divider

This block turns one fast clock into three slower square waves. The first is a clock for a switched-capacitor filter, running at one quarter of the input rate. The other two are a pair of square waves at one hundredth of the input rate, a quarter period apart. A pair of external narrow bandpass filters can smooth these two waves into a sine and cosine source. Every stage runs in the single input clock domain. The divide-by-2 stages act on detected rising edges of the toggle outputs, so no clock is derived from logic.

The quadrature path first divides by 25 in two cascaded modulo-5 counters. Their terminal pulse drives a toggle flip-flop that has a true and a complement output. Each of those outputs is then halved on its own rising edges. Because the complement rises 25 input cycles after the true output, the two halved waves sit 90 degrees apart.

By default the second wave lags the sine and therefore forms a negative cosine. The polarity input inverts that channel to give a true cosine, and it leaves the sine untouched. Edge numbers below count rising clock edges after the last edge at which reset was sampled high: the first edge with reset low is edge 1.

Top module: `quad_clk_div`

## Requirements
- R1: `filt_clk_o` is a square wave at one quarter of the clock rate with equal high and low times. It is low after reset, high after edges 2 and 3, low after edges 4 and 5, and the pattern repeats.
- R2: The sine wave and the uninverted second channel change level only at edges spaced exactly 25 clocks apart, taken across both channels together. This spacing comes from the divide-by-25 prescaler.
- R3: `sin_o` has a period of 100 clocks: 50 clocks high and 50 clocks low.
- R4: After reset is released, `sin_o` first goes high at edge 26 and stays high until edge 76.
- R5: With `cos_invert` low, `cos_o` is `sin_o` delayed by 25 clocks, which is a negative cosine. It first goes high at edge 51.
- R6: With `cos_invert` high, `cos_o` is the complement of the R5 waveform, which is a true cosine that leads the sine by 25 clocks. The change takes effect in the same cycle as the input.
- R7: `cos_invert` has no effect on the timing or level of `sin_o` or `filt_clk_o`.
- R8: While `rst` is sampled high, `sin_o` and `filt_clk_o` are low and `cos_o` equals `cos_invert`. Every counter restarts, so the timing of R1, R4 and R5 holds again from edge 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| cos_invert | input | 1 | 1 selects a true cosine on `cos_o`, 0 selects a negative cosine |
| filt_clk_o | output | 1 | Filter clock at one quarter of the clock rate |
| sin_o | output | 1 | Sine-phase square wave at one hundredth of the clock rate |
| cos_o | output | 1 | Cosine-phase square wave at one hundredth of the clock rate |

## Verification
Three properties are checked on every cycle: the filter clock inverts every second cycle, each level of the sine wave lasts exactly 50 cycles, and the uninverted second channel is low when the sine rises and high when it falls. The assertions also check the output levels during reset. The bench's scenarios cover the rest. They show the exact edge numbers of the first transitions after a reset in mid-run, the 25-cycle spacing between channel edges, and the fact that changing the polarity input, even every few cycles, never shifts the sine or the filter clock.

// File: rtl/qcd_pkg.sv
package qcd_pkg;

    // Default division ratios
    localparam int FILT_DIV_DEF  = 4;   // filter clock ratio, even
    localparam int STAGE_DIV_DEF = 5;   // ratio of one prescaler stage
    localparam int STAGES_DEF    = 2;   // number of cascaded prescaler stages

    // Output of the toggle stage: true and complement
    typedef struct packed {
        logic q;
        logic qn;
    } tog_pair_t;

    // Quadrature pair before polarity select
    typedef struct packed {
        logic sin_ph;
        logic cos_ph;
    } quad_pair_t;

    // Integer power, used to size the prescaler
    function automatic int ipow(input int base, input int ex);
        int r;
        r = 1;
        for (int i = 0; i < ex; i++) r = r * base;
        return r;
    endfunction

    // Width of a counter that spans 0..n-1, never zero
    function automatic int cnt_width(input int n);
        return (n > 2) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/qcd_modn.sv
module qcd_modn
    import qcd_pkg::*;
#(
    parameter int N = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tc
);
    localparam int W = cnt_width(N);
    localparam logic [W-1:0] LAST = W'(N - 1);

    logic [W-1:0] cnt;

    // Terminal pulse: this stage wraps on the current enabled cycle
    assign tc = en && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (en) begin
            if (cnt == LAST) cnt <= '0;
            else             cnt <= cnt + W'(1);
        end
    end
endmodule

// File: rtl/qcd_filt_div.sv
module qcd_filt_div
    import qcd_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic clk_o
);
    localparam int HALF = DIV / 2;
    localparam int W    = cnt_width(HALF);
    localparam logic [W-1:0] LAST = W'(HALF - 1);

    logic [W-1:0] cnt;
    logic         lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            lvl <= 1'b0;
        end else if (cnt == LAST) begin
            cnt <= '0;
            lvl <= ~lvl;
        end else begin
            cnt <= cnt + W'(1);
        end
    end

    assign clk_o = lvl;
endmodule

// File: rtl/qcd_toggle.sv
module qcd_toggle
    import qcd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      step,
    output tog_pair_t pair
);
    logic q;

    always_ff @(posedge clk) begin
        if (rst)       q <= 1'b0;
        else if (step) q <= ~q;
    end

    assign pair.q  = q;
    assign pair.qn = ~q;
endmodule

// File: rtl/qcd_halver.sv
module qcd_halver #(
    parameter logic PREV_INIT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic src,
    output logic half_o
);
    logic prev;
    logic lvl;
    logic rise;

    // A rising edge of the source, seen in the clock domain
    assign rise = src && !prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= PREV_INIT;
            lvl  <= 1'b0;
        end else begin
            prev <= src;
            if (rise) lvl <= ~lvl;
        end
    end

    assign half_o = lvl;
endmodule

// File: rtl/quad_clk_div.sv
module quad_clk_div
    import qcd_pkg::*;
#(
    parameter int FILT_DIV  = FILT_DIV_DEF,
    parameter int STAGE_DIV = STAGE_DIV_DEF,
    parameter int STAGES    = STAGES_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic cos_invert,
    output logic filt_clk_o,
    output logic sin_o,
    output logic cos_o
);
    localparam int PRESCALE = ipow(STAGE_DIV, STAGES);

    // Filter clock path
    qcd_filt_div #(.DIV(FILT_DIV)) u_filt (
        .clk   (clk),
        .rst   (rst),
        .clk_o (filt_clk_o)
    );

    // Cascaded odd prescaler: each stage counts the wraps of the one before
    logic [STAGES:0] wrap;
    assign wrap[0] = 1'b1;

    for (genvar g = 0; g < STAGES; g++) begin : g_pre
        qcd_modn #(.N(STAGE_DIV)) u_stage (
            .clk (clk),
            .rst (rst),
            .en  (wrap[g]),
            .tc  (wrap[g+1])
        );
    end

    // Toggle stage on the prescaler pulse
    tog_pair_t tog;
    qcd_toggle u_tog (
        .clk  (clk),
        .rst  (rst),
        .step (wrap[STAGES]),
        .pair (tog)
    );

    // Halve each toggle output on its own rising edges
    quad_pair_t quad;
    qcd_halver #(.PREV_INIT(1'b0)) u_half_sin (
        .clk    (clk),
        .rst    (rst),
        .src    (tog.q),
        .half_o (quad.sin_ph)
    );
    qcd_halver #(.PREV_INIT(1'b1)) u_half_cos (
        .clk    (clk),
        .rst    (rst),
        .src    (tog.qn),
        .half_o (quad.cos_ph)
    );

    assign sin_o = quad.sin_ph;
    assign cos_o = quad.cos_ph ^ cos_invert;
endmodule

// File: rtl/qcd_checker.sv
module qcd_checker #(
    parameter int HALF = 50
) (
    input logic clk,
    input logic rst,
    input logic cos_invert,
    input logic filt_clk_o,
    input logic sin_o,
    input logic cos_o
);
    localparam int W = $clog2(HALF + 1) + 1;

    logic [1:0]   live;
    logic         sin_prev;
    logic         sin_seen;
    logic [W-1:0] sin_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            live     <= '0;
            sin_prev <= 1'b0;
            sin_seen <= 1'b0;
            sin_run  <= '0;
        end else begin
            if (live != 2'd3) live <= live + 2'd1;
            sin_prev <= sin_o;
            if (sin_o != sin_prev) begin
                sin_run  <= '0;
                sin_seen <= 1'b1;
            end else if (sin_run != W'(HALF)) begin
                sin_run <= sin_run + W'(1);
            end
        end
    end

    AST_FILT_QUARTER: assert property (@(posedge clk) disable iff (rst)
        (live == 2'd3) |-> (filt_clk_o != $past(filt_clk_o, 2))); // R1

    AST_SIN_HALF_PERIOD: assert property (@(posedge clk) disable iff (rst)
        (sin_seen && (sin_o != sin_prev)) |-> (sin_run == W'(HALF - 1))); // R3

    AST_SIN_NO_LONG_LEVEL: assert property (@(posedge clk) disable iff (rst)
        sin_run < W'(HALF)); // R3

    AST_QUAD_ORDER: assert property (@(posedge clk) disable iff (rst)
        (sin_o != sin_prev) |-> ((cos_o ^ cos_invert) == !sin_o)); // R5

    AST_RESET_LEVELS: assert property (@(posedge clk)
        rst |=> (!sin_o && !filt_clk_o && (cos_o == cos_invert))); // R8
endmodule

bind quad_clk_div qcd_checker #(
    .HALF(qcd_pkg::ipow(STAGE_DIV, STAGES) * 2)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cos_invert (cos_invert),
    .filt_clk_o (filt_clk_o),
    .sin_o      (sin_o),
    .cos_o      (cos_o)
);

// File: tb/quad_clk_div_tb.sv
module quad_clk_div_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic inv = 1'b0;
    logic filt_clk_o, sin_o, cos_o;

    int checks = 0;
    int errors = 0;
    int n      = 0;     // edges since reset release
    int last_chg = 0;   // edge of the last change on either channel
    logic prev_sin = 1'b0;
    logic prev_raw = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    quad_clk_div u_dut (
        .clk        (clk),
        .rst        (rst),
        .cos_invert (inv),
        .filt_clk_o (filt_clk_o),
        .sin_o      (sin_o),
        .cos_o      (cos_o)
    );

    function automatic logic m_filt(input int k);
        return ((k / 2) % 2) == 1;
    endfunction

    function automatic logic m_sin(input int k);
        return (k >= 26) && (((k - 26) % 100) < 50);
    endfunction

    function automatic logic m_cosraw(input int k);
        return (k >= 51) && (((k - 51) % 100) < 50);
    endfunction

    task automatic cmp(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s edge %0d actual %b expected %b", tag, n, act, exp);
        end
    endtask

    task automatic step();
        logic raw;
        @(posedge clk);
        if (rst) n = 0;
        else     n = n + 1;
        @(negedge clk);
        if (n == 0) begin
            cmp(filt_clk_o, 1'b0, "R8 filt");
            cmp(sin_o, 1'b0, "R8 sin");
            cmp(cos_o, inv, "R8 cos");
            last_chg = 0;
            prev_sin = 1'b0;
            prev_raw = 1'b0;
        end else begin
            cmp(filt_clk_o, m_filt(n), inv ? "R7 filt" : "R1 filt");
            if (n <= 100) cmp(sin_o, m_sin(n), "R4 sin");
            else          cmp(sin_o, m_sin(n), inv ? "R7 sin" : "R3 sin");
            cmp(cos_o, m_cosraw(n) ^ inv, inv ? "R6 cos" : "R5 cos");
            raw = cos_o ^ inv;
            if ((sin_o != prev_sin) || (raw != prev_raw)) begin
                if (last_chg != 0) begin
                    checks++;
                    if (n - last_chg != 25) begin
                        errors++;
                        $display("FAIL R2 edge spacing actual %0d expected 25", n - last_chg);
                    end
                end
                last_chg = n;
            end
            prev_sin = sin_o;
            prev_raw = raw;
        end
    endtask

    initial begin : wdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) step();
        rst = 1'b0;
        repeat (400) step();              // R1 R3 R4 R5
        inv = 1'b1;
        repeat (300) step();              // R6 R7
        rst = 1'b1;
        repeat (2) step();                // R8 mid-run
        rst = 1'b0;
        repeat (250) step();              // R4 with true cosine
        for (int i = 0; i < 40; i++) begin
            inv = ~inv;                   // R7 rapid polarity changes
            repeat (7) step();
        end
        inv = 1'b0;
        rst = 1'b1;
        step();
        rst = 1'b0;
        repeat (160) step();              // R2 R5 after short reset
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule